// File: doc/BRIEF.md
# Countdown Timer with Programmable Clock Output

This block runs on a 32.768 kHz clock. A single free-running prescaler produces synchronous tick enables at 4096 Hz, 64 Hz, 1 Hz and once a minute. Those ticks drive an 8-bit binary down counter. When the counter expires it raises a one-cycle event that the status logic uses to set its flag. In pulse mode it also produces an interrupt pulse whose width depends on the chosen tick rate and on whether the programmed count is 1.

The same prescaler drives a clock output pin. That pin carries either the input clock itself or one of three divided square waves, or it is held low when disabled. Three byte-wide write ports load the timer setup, the timer count and the clock-output setup. The present count is available for readback. The status flag, its interrupt enable and the level/pulse mode bit arrive as inputs, because flag storage and interrupt merging live outside this block.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 0, the event and interrupt outputs are low, the timer is disabled with source code 11, and the clock output is enabled with selector 00, so that it follows the input clock.
- R2: Timer setup bit 7 enables counting and bits 1:0 pick the source. With code 00 (4096 Hz) one count takes 8 input clocks, so a programmed value n gives an expiry period of 8·n clocks.
- R3: Source code 01 (64 Hz) takes 512 input clocks per count.
- R4: Source code 10 (1 Hz) takes 32768 clocks per count. Code 11 takes SEC_PER_MIN one-second ticks per count.
- R5: A write to the count port loads the value as both the count and the reload value; it reads back on the next cycle and the countdown restarts from it. A loaded value of 0 stops the timer, and no event follows.
- R6: On expiry the counter reloads the last written value and keeps counting down, so events repeat with a fixed period.
- R7: While bit 7 of the timer setup is 0, the count holds its value and no event occurs.
- R8: In pulse mode with source 00, the interrupt pulse lasts 8 clocks when n > 1 and 4 clocks when n = 1.
- R9: In pulse mode with source 01, the interrupt pulse lasts 512 clocks when n > 1 and 256 clocks when n = 1.
- R10: In pulse mode with source 10 or 11, the interrupt pulse lasts 512 clocks for any n.
- R11: In level mode the interrupt output equals the status flag input ANDed with the interrupt enable. In pulse mode the pulse is also gated by the interrupt enable.
- R12: The expiry event and the start of the interrupt pulse occur in the same clock cycle.
- R13: Clock-output setup bit 7 enables the pin, and bits 1:0 select 32768, 1024, 32 or 1 Hz (00..11). The 1024 Hz wave is high for 16 clocks and low for 16 clocks; the 32 Hz wave is high for 512 clocks. When the pin is disabled it is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmr_ctrl_wr_i | input | 1 | Write strobe for the timer setup byte |
| tmr_ctrl_i | input | 8 | Timer setup: bit 7 enable, bits 1:0 source |
| tmr_val_wr_i | input | 1 | Write strobe for the count byte |
| tmr_val_i | input | 8 | Count value to load |
| clk_ctrl_wr_i | input | 1 | Write strobe for the clock-output setup byte |
| clk_ctrl_i | input | 8 | Clock-output setup: bit 7 enable, bits 1:0 frequency |
| pulse_mode_i | input | 1 | 1 = pulsed interrupt, 0 = level interrupt |
| irq_en_i | input | 1 | Timer interrupt enable |
| tmr_flag_i | input | 1 | Stored timer flag from the status logic |
| tmr_count_o | output | 8 | Present count |
| tmr_fire_o | output | 1 | One-cycle expiry event |
| tmr_irq_o | output | 1 | Timer interrupt, active high |
| clk_out_o | output | 1 | Selected clock output |

## Verification
The assertions assume the following about the block's inputs:
- The count write strobe is a one-cycle pulse applied on a clock edge.
- After release, reset stays inactive for the rest of the run.
- The status flag input is driven by separate logic, so the properties make no claim about it beyond the gating of R11.

The stimulus keeps within these assumptions:
- It changes inputs only at falling edges and holds each write strobe for exactly one cycle.
- It releases reset once.
- It shortens the minute divider through SEC_PER_MIN, so the slowest source completes within the run.
- It measures periods and widths from observed events rather than from an assumed prescaler phase.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    SRC_4096 = 2'b00,
    SRC_64   = 2'b01,
    SRC_1    = 2'b10,
    SRC_MIN  = 2'b11
  } tmr_src_e;

  typedef enum logic [1:0] {
    OUT_32768 = 2'b00,
    OUT_1024  = 2'b01,
    OUT_32    = 2'b10,
    OUT_1     = 2'b11
  } clk_sel_e;

  typedef struct packed {
    logic t4096;
    logic t64;
    logic t1;
    logic tmin;
  } ticks_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_timer_pkg::*;
#(
  parameter int DIV_BITS    = 15,
  parameter int SEC_PER_MIN = 60
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output ticks_t              ticks_o,
  output logic [DIV_BITS-1:0] div_o
);
  localparam int SH_4096 = DIV_BITS - 12;
  localparam int SH_64   = DIV_BITS - 6;
  localparam int SW      = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [SW-1:0] SEC_LAST = SW'(SEC_PER_MIN - 1);

  logic [DIV_BITS-1:0] div_q;
  logic [SW-1:0]       sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        sec_q <= '0;
    else if (&div_q) sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
  end

  always_comb begin
    ticks_o.t4096 = &div_q[SH_4096-1:0];
    ticks_o.t64   = &div_q[SH_64-1:0];
    ticks_o.t1    = &div_q;
    ticks_o.tmin  = (&div_q) && (sec_q == SEC_LAST);
  end

  assign div_o = div_q;

  assert_sec_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q <= SEC_LAST);
  assert_sec_steps_on_second_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q != $past(sec_q)) |-> $past(&div_q));
endmodule

// File: rtl/tick_countdown.sv
module tick_countdown
  import tick_timer_pkg::*;
#(
  parameter int CW        = 8,
  parameter int W_FAST    = 8,
  parameter int W_SLOW    = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ticks_t        ticks_i,
  input  logic          en_i,
  input  tmr_src_e      src_i,
  input  logic          val_wr_i,
  input  logic [CW-1:0] val_i,
  output logic [CW-1:0] count_o,
  output logic          fire_o,
  output logic          pulse_o
);
  localparam int PW = $clog2(W_SLOW + 1);
  localparam logic [PW-1:0] PW_FAST  = PW'(W_FAST);
  localparam logic [PW-1:0] PW_SLOW  = PW'(W_SLOW);

  logic [CW-1:0] cnt_q, reload_q;
  logic          fire_q;
  logic [PW-1:0] pw_q, width;
  logic          tick, expire;

  always_comb begin
    unique case (src_i)
      SRC_4096: tick = ticks_i.t4096;
      SRC_64:   tick = ticks_i.t64;
      SRC_1:    tick = ticks_i.t1;
      default:  tick = ticks_i.tmin;
    endcase
  end

  assign expire = !val_wr_i && en_i && tick && (cnt_q == CW'(1));

  // n == 1 halves the pulse for the two fast sources only
  always_comb begin
    unique case (src_i)
      SRC_4096: width = (reload_q == CW'(1)) ? (PW_FAST >> 1) : PW_FAST;
      SRC_64:   width = (reload_q == CW'(1)) ? (PW_SLOW >> 1) : PW_SLOW;
      default:  width = PW_SLOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      fire_q   <= 1'b0;
    end else begin
      fire_q <= expire;
      if (val_wr_i) begin
        cnt_q    <= val_i;
        reload_q <= val_i;
      end else if (expire) begin
        cnt_q <= reload_q;
      end else if (en_i && tick && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pw_q <= '0;
    else if (expire)     pw_q <= width;
    else if (pw_q != '0) pw_q <= pw_q - 1'b1;
  end

  assign count_o = cnt_q;
  assign fire_o  = fire_q;
  assign pulse_o = (pw_q != '0);

  assert_fire_reloads_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> (cnt_q == reload_q));
  assert_write_blocks_fire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> !$past(val_wr_i));
  assert_count_never_rises_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(val_wr_i) && !fire_q) |-> (cnt_q <= $past(cnt_q)));
  assert_hold_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_i) && !$past(val_wr_i)) |-> $stable(cnt_q));
  assert_pulse_with_fire_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> pulse_o);
  assert_pulse_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_q <= PW_SLOW);
endmodule

// File: rtl/tick_clkout.sv
module tick_clkout
  import tick_timer_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIV_BITS-1:0] div_i,
  input  logic                en_i,
  input  clk_sel_e            sel_i,
  output logic                clk_o
);
  localparam int TAP_1024 = DIV_BITS - 11;
  localparam int TAP_32   = DIV_BITS - 6;
  localparam int TAP_1    = DIV_BITS - 1;

  logic wave;

  always_comb begin
    unique case (sel_i)
      OUT_32768: wave = clk_i;
      OUT_1024:  wave = div_i[TAP_1024];
      OUT_32:    wave = div_i[TAP_32];
      default:   wave = div_i[TAP_1];
    endcase
  end

  assign clk_o = en_i & wave;

  assert_clkout_low_when_off_R13: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !en_i |-> !clk_o);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DIV_BITS    = 15,
  parameter int SEC_PER_MIN = 60,
  parameter int CW          = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tmr_ctrl_wr_i,
  input  logic [7:0]    tmr_ctrl_i,
  input  logic          tmr_val_wr_i,
  input  logic [CW-1:0] tmr_val_i,
  input  logic          clk_ctrl_wr_i,
  input  logic [7:0]    clk_ctrl_i,
  input  logic          pulse_mode_i,
  input  logic          irq_en_i,
  input  logic          tmr_flag_i,
  output logic [CW-1:0] tmr_count_o,
  output logic          tmr_fire_o,
  output logic          tmr_irq_o,
  output logic          clk_out_o
);
  localparam int W_FAST = 1 << (DIV_BITS - 12);
  localparam int W_SLOW = 1 << (DIV_BITS - 6);

  logic                tmr_en_q, clk_en_q;
  tmr_src_e            tmr_src_q;
  clk_sel_e            clk_sel_q;
  ticks_t              ticks;
  logic [DIV_BITS-1:0] div;
  logic                pulse;
  logic                unused_ctrl;

  assign unused_ctrl = ^{tmr_ctrl_i[6:2], clk_ctrl_i[6:2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_en_q  <= 1'b0;
      tmr_src_q <= SRC_MIN;
      clk_en_q  <= 1'b1;
      clk_sel_q <= OUT_32768;
    end else begin
      if (tmr_ctrl_wr_i) begin
        tmr_en_q  <= tmr_ctrl_i[7];
        tmr_src_q <= tmr_src_e'(tmr_ctrl_i[1:0]);
      end
      if (clk_ctrl_wr_i) begin
        clk_en_q  <= clk_ctrl_i[7];
        clk_sel_q <= clk_sel_e'(clk_ctrl_i[1:0]);
      end
    end
  end

  tick_prescaler #(.DIV_BITS(DIV_BITS), .SEC_PER_MIN(SEC_PER_MIN)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ticks_o(ticks),
    .div_o  (div)
  );

  tick_countdown #(.CW(CW), .W_FAST(W_FAST), .W_SLOW(W_SLOW)) u_cd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ticks_i (ticks),
    .en_i    (tmr_en_q),
    .src_i   (tmr_src_q),
    .val_wr_i(tmr_val_wr_i),
    .val_i   (tmr_val_i),
    .count_o (tmr_count_o),
    .fire_o  (tmr_fire_o),
    .pulse_o (pulse)
  );

  tick_clkout #(.DIV_BITS(DIV_BITS)) u_co (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (div),
    .en_i  (clk_en_q),
    .sel_i (clk_sel_q),
    .clk_o (clk_out_o)
  );

  assign tmr_irq_o = irq_en_i & (pulse_mode_i ? pulse : tmr_flag_i);

  assert_irq_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !tmr_irq_o);
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tc_wr = 0, tv_wr = 0, cc_wr = 0;
  logic [7:0] tc = 0, tv = 0, cc = 0;
  logic       pmode = 1, ien = 1, flag = 0;
  logic [7:0] count;
  logic       fire, irq, cko;
  int         n_checks = 0, n_fail = 0, cyc = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  tick_timer #(.SEC_PER_MIN(2)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tmr_ctrl_wr_i(tc_wr), .tmr_ctrl_i(tc),
    .tmr_val_wr_i(tv_wr), .tmr_val_i(tv),
    .clk_ctrl_wr_i(cc_wr), .clk_ctrl_i(cc),
    .pulse_mode_i(pmode), .irq_en_i(ien), .tmr_flag_i(flag),
    .tmr_count_o(count), .tmr_fire_o(fire), .tmr_irq_o(irq), .clk_out_o(cko)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
    end
  end

  task automatic wr_tctrl(input logic [7:0] d);
    @(negedge clk); tc = d; tc_wr = 1; @(negedge clk); tc_wr = 0;
  endtask
  task automatic wr_val(input logic [7:0] d);
    @(negedge clk); tv = d; tv_wr = 1; @(negedge clk); tv_wr = 0;
  endtask
  task automatic wr_cctrl(input logic [7:0] d);
    @(negedge clk); cc = d; cc_wr = 1; @(negedge clk); cc_wr = 0;
  endtask

  // returns negedges waited until fire seen, or -1
  task automatic wait_fire(input int limit, output int waited);
    waited = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (fire) begin waited = i; break; end
    end
  endtask

  // called at a fire negedge: pulse width and (optionally) period to next fire
  task automatic measure(input bit want_per, input int limit, output int w, output int per);
    bit run = 1;
    w = irq ? 1 : 0; per = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (run && irq) w++; else run = 0;
      if (want_per && fire) begin per = i; break; end
      if (!want_per && !run) break;
    end
  endtask

  task automatic t_reset();
    check(count == 0, "R1 count", count, 0);
    check(fire == 0, "R1 fire", fire, 0);
    check(irq == 0, "R1 irq", irq, 0);
    @(posedge clk); #1;
    check(cko == 1, "R1 clkout high phase", cko, 1);
    @(negedge clk);
    check(cko == 0, "R1 clkout low phase", cko, 0);
  endtask

  task automatic t_fast_n3();
    int wt, w, p;
    wr_tctrl(8'h80); wr_val(8'd3);
    wait_fire(100, wt);
    check(wt > 0, "R2 first expiry 4096Hz", wt, 1);
    check(irq == 1, "R12 irq with fire", irq, 1);
    check(count == 3, "R6 reload value", count, 3);
    measure(1, 100, w, p);
    check(w == 8, "R8 width n>1", w, 8);
    check(p == 24, "R2 period n=3", p, 24);
    measure(1, 100, w, p);
    check(p == 24, "R6 periodic repeat", p, 24);
  endtask

  task automatic t_fast_n1();
    int wt, w, p;
    wr_val(8'd1);
    wait_fire(100, wt);
    measure(1, 100, w, p);
    check(w == 4, "R8 width n=1", w, 4);
    check(p == 8, "R2 period n=1", p, 8);
  endtask

  task automatic t_64();
    int wt, w, p;
    wr_tctrl(8'h81); wr_val(8'd2);
    wait_fire(2000, wt);
    measure(1, 3000, w, p);
    check(w == 512, "R9 width n>1", w, 512);
    check(p == 1024, "R3 period n=2", p, 1024);
    wr_val(8'd1);
    wait_fire(2000, wt);
    measure(1, 3000, w, p);
    check(w == 256, "R9 width n=1", w, 256);
    check(p == 512, "R3 period n=1", p, 512);
  endtask

  task automatic t_restart();
    int wt;
    wr_val(8'd200);
    repeat (600) @(negedge clk);
    @(negedge clk); tv = 8'd3; tv_wr = 1; @(negedge clk); tv_wr = 0;
    check(count == 3, "R5 load readback", count, 3);
    wait_fire(3000, wt);
    check(wt > 1023 && wt <= 1536, "R5 restart window", wt, 1536);
  endtask

  task automatic t_stop_and_hold();
    int wt;
    wr_tctrl(8'h80); wr_val(8'd0);
    wait_fire(300, wt);
    check(wt == -1, "R5 zero stops", wt, -1);
    check(count == 0, "R5 zero count", count, 0);
    wr_tctrl(8'h00); wr_val(8'd5);
    wait_fire(300, wt);
    check(wt == -1, "R7 disabled no fire", wt, -1);
    check(count == 5, "R7 disabled hold", count, 5);
  endtask

  task automatic t_level();
    pmode = 0; flag = 1; ien = 1; @(negedge clk);
    check(irq == 1, "R11 level follows flag", irq, 1);
    flag = 0; @(negedge clk);
    check(irq == 0, "R11 level flag low", irq, 0);
    flag = 1; ien = 0; @(negedge clk);
    check(irq == 0, "R11 level gated", irq, 0);
    flag = 0; ien = 1; pmode = 1;
  endtask

  task automatic t_slow();
    int wt, w, p;
    wr_tctrl(8'h82); wr_val(8'd1);
    wait_fire(33000, wt);
    check(wt > 0, "R4 1Hz expiry", wt, 1);
    measure(1, 33000, w, p);
    check(w == 512, "R10 width 1Hz", w, 512);
    check(p == 32768, "R4 period 1Hz", p, 32768);
    wr_tctrl(8'h83); wr_val(8'd1);
    wait_fire(66000, wt);
    check(wt > 0, "R4 minute expiry", wt, 1);
    measure(0, 1000, w, p);
    check(w == 512, "R10 width minute", w, 512);
    wr_tctrl(8'h00);
  endtask

  task automatic t_clkout();
    int hi, lo;
    bit prev;
    wr_cctrl(8'h81);
    @(negedge clk); prev = cko;
    while (!(cko && !prev)) begin prev = cko; @(negedge clk); end
    hi = 0; while (cko) begin hi++; @(negedge clk); end
    lo = 0; while (!cko) begin lo++; @(negedge clk); end
    check(hi == 16, "R13 1024Hz high", hi, 16);
    check(lo == 16, "R13 1024Hz low", lo, 16);
    wr_cctrl(8'h82);
    @(negedge clk); prev = cko;
    while (!(cko && !prev)) begin prev = cko; @(negedge clk); end
    hi = 0; while (cko) begin hi++; @(negedge clk); end
    check(hi == 512, "R13 32Hz high", hi, 512);
    wr_cctrl(8'h00);
    hi = 0;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #1; if (cko) hi++;
    end
    check(hi == 0, "R13 disabled low", hi, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fast_n3();
    t_fast_n1();
    t_64();
    t_restart();
    t_stop_and_hold();
    t_level();
    t_clkout();
    t_slow();
    summary();
  end
endmodule